// File: doc/BRIEF.md
# Packed-Lane Integer Multiply-Add Unit

This unit performs one multiply-accumulate per instruction on packed integer data. It decodes a 64-bit instruction word and picks a sub-word lane from source A and from source B. Each lane is a byte, a halfword or the whole word. It widens each lane to 32 bits as signed or unsigned, according to that operand's own flag. It multiplies the two widened lanes and adds the full 32-bit source C. The source values arrive on their own ports next to the instruction. Source B can be replaced by a 16-bit immediate carried inside the instruction.

A valid strobe launches the operation. The result and its destination index leave the unit from a single register stage. Some instruction options are not implemented: saturation, scaling, negation of A or C, and a condition-code update. If any of them is requested, the unit produces no result. It raises an unsupported indication instead, so that the issuing logic can trap or fall back to another path.

Top module: `lane_mad_unit`

## Requirements
- R1: The width codes are 0 = byte, 1 = byte, 2 = halfword and 3 = full word. A takes its width from insn[38:37] and its lane selector from insn[37:36]. B takes its width from insn[30:29] and its selector from insn[29:28]. In each pair the middle bit is shared between the width and the selector.
- R2: A byte lane is bits [sel*8 +: 8] of the source. A halfword lane uses only selector bit 0: 0 selects bits [15:0] and 1 selects bits [31:16]. A word lane is the whole source.
- R3: insn[48] is the signedness flag for A and insn[49] is the flag for B. When a flag is set, the byte or halfword lane of that operand is sign-extended to 32 bits. When it is clear, the lane is zero-extended. The flags have no effect on word lanes.
- R4: When insn[50] is 0, B is the immediate insn[35:20], taken as a halfword at lane 0. The B width field, the B selector field and the src_b port are then ignored.
- R5: out_result equals lane(A) * lane(B) + src_c, truncated to 32 bits.
- R6: out_dest carries insn[7:0] of the instruction that produced out_result.
- R7: If in_valid is high at a rising edge and the instruction is supported, out_valid is high for exactly the following cycle. If in_valid is low, out_valid and out_unsup are low in the following cycle.
- R8: An instruction counts as unsupported if any of these is set: insn[47] (condition code), a nonzero insn[52:51] (scale), insn[53] (negate C), insn[54] (negate A) or insn[55] (saturate). For such an instruction, out_unsup is high in the following cycle and out_valid stays low. out_dest and out_result keep their previous values.
- R9: While rst_n is low, out_valid, out_unsup, out_dest and out_result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and sources are valid this cycle |
| insn | input | 64 | Instruction word |
| src_a | input | 32 | Source A register value |
| src_b | input | 32 | Source B register value |
| src_c | input | 32 | Addend C |
| out_valid | output | 1 | out_result and out_dest hold a new result |
| out_unsup | output | 1 | The last issued instruction requested an unsupported option |
| out_dest | output | 8 | Destination index of the result |
| out_result | output | 32 | Multiply-add result |

## Verification
Every result of this unit is due one clock after its stimulus. out_valid, out_unsup, out_dest and out_result all come from one register stage, which is loaded at the rising edge where in_valid is sampled. The bench applies each instruction on a falling edge and drops in_valid on the next falling edge. It reads all four outputs at that falling edge, which is half a period after the loading edge. For unsupported and idle cycles, the bench compares out_dest and out_result with the values left by the previous accepted instruction.

// File: rtl/lmad_pkg.sv
package lmad_pkg;

    localparam int LMAD_DATA_W = 32;
    localparam int LMAD_INSN_W = 64;
    localparam int LMAD_DEST_W = 8;
    localparam int LMAD_IMM_W  = 16;

    typedef enum logic [1:0] {
        WID_BYTE_LO = 2'd0,
        WID_BYTE_HI = 2'd1,
        WID_HALF    = 2'd2,
        WID_WORD    = 2'd3
    } lane_wid_e;

    typedef struct packed {
        logic [LMAD_DEST_W-1:0] dest;
        lane_wid_e              a_wid;
        logic [1:0]             a_sel;
        lane_wid_e              b_wid;
        logic [1:0]             b_sel;
        logic                   a_sgn;
        logic                   b_sgn;
        logic                   b_is_reg;
        logic [LMAD_IMM_W-1:0]  imm;
        logic                   unsup;
    } lmad_fields_t;

    typedef struct packed {
        logic                   valid;
        logic                   unsup;
        logic [LMAD_DEST_W-1:0] dest;
        logic [LMAD_DATA_W-1:0] result;
    } lmad_out_t;

endpackage

// File: rtl/lmad_decode.sv
module lmad_decode
    import lmad_pkg::*;
(
    input  logic [LMAD_INSN_W-1:0] insn,
    output lmad_fields_t           fields
);

    logic unused_insn_bits;
    assign unused_insn_bits = ^{insn[19:8], insn[46:39], insn[63:56]};

    always_comb begin
        fields          = '0;
        fields.dest     = insn[7:0];
        fields.b_sel    = insn[29:28];
        fields.b_wid    = lane_wid_e'(insn[30:29]);
        fields.a_sel    = insn[37:36];
        fields.a_wid    = lane_wid_e'(insn[38:37]);
        fields.a_sgn    = insn[48];
        fields.b_sgn    = insn[49];
        fields.b_is_reg = insn[50];
        fields.imm      = insn[35:20];
        // options not implemented: condition code, scale, negates, saturate
        fields.unsup    = insn[47] | (|insn[52:51]) | insn[53] | insn[54] | insn[55];
    end

endmodule

// File: rtl/lmad_lane_extract.sv
module lmad_lane_extract
    import lmad_pkg::*;
#(
    parameter int DATA_W = LMAD_DATA_W
) (
    input  logic [DATA_W-1:0] val,
    input  lane_wid_e         wid,
    input  logic [1:0]        sel,
    input  logic              sgn,
    output logic [DATA_W-1:0] lane
);

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    logic [BYTE_W-1:0] byte_pick;
    logic [HALF_W-1:0] half_pick;

    always_comb begin
        byte_pick = val[{sel, 3'b000} +: BYTE_W];
        half_pick = sel[0] ? val[2*HALF_W-1:HALF_W] : val[HALF_W-1:0];
        unique case (wid)
            WID_BYTE_LO, WID_BYTE_HI:
                lane = {{(DATA_W-BYTE_W){sgn & byte_pick[BYTE_W-1]}}, byte_pick};
            WID_HALF:
                lane = {{(DATA_W-HALF_W){sgn & half_pick[HALF_W-1]}}, half_pick};
            default:
                lane = val;
        endcase
    end

endmodule

// File: rtl/lane_mad_unit.sv
module lane_mad_unit
    import lmad_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [63:0] insn,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    input  logic [31:0] src_c,
    output logic        out_valid,
    output logic        out_unsup,
    output logic [7:0]  out_dest,
    output logic [31:0] out_result
);

    localparam int NUM_SRC = 2;
    localparam int OP_A    = 0;
    localparam int OP_B    = 1;

    lmad_fields_t fld;
    lmad_out_t    st_d, st_q;

    logic [LMAD_DATA_W-1:0] op_val  [NUM_SRC];
    lane_wid_e              op_wid  [NUM_SRC];
    logic [1:0]             op_sel  [NUM_SRC];
    logic                   op_sgn  [NUM_SRC];
    logic [LMAD_DATA_W-1:0] op_lane [NUM_SRC];
    logic [LMAD_DATA_W-1:0] mad_d;

    lmad_decode u_decode (
        .insn   (insn),
        .fields (fld)
    );

    // operand routing: an immediate B is forced to halfword lane 0
    always_comb begin
        op_val[OP_A] = src_a;
        op_wid[OP_A] = fld.a_wid;
        op_sel[OP_A] = fld.a_sel;
        op_sgn[OP_A] = fld.a_sgn;
        op_sgn[OP_B] = fld.b_sgn;
        if (fld.b_is_reg) begin
            op_val[OP_B] = src_b;
            op_wid[OP_B] = fld.b_wid;
            op_sel[OP_B] = fld.b_sel;
        end else begin
            op_val[OP_B] = {{(LMAD_DATA_W-LMAD_IMM_W){1'b0}}, fld.imm};
            op_wid[OP_B] = WID_HALF;
            op_sel[OP_B] = 2'd0;
        end
    end

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_lane
        lmad_lane_extract #(
            .DATA_W (LMAD_DATA_W)
        ) u_extract (
            .val  (op_val[gi]),
            .wid  (op_wid[gi]),
            .sel  (op_sel[gi]),
            .sgn  (op_sgn[gi]),
            .lane (op_lane[gi])
        );
    end

    assign mad_d = op_lane[OP_A] * op_lane[OP_B] + src_c;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.unsup = 1'b0;
        if (in_valid) begin
            if (fld.unsup) begin
                st_d.unsup = 1'b1;
            end else begin
                st_d.valid  = 1'b1;
                st_d.dest   = fld.dest;
                st_d.result = mad_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_unsup  = st_q.unsup;
    assign out_dest   = st_q.dest;
    assign out_result = st_q.result;

    // R7: an accepted supported instruction produces a result one cycle later
    a_r7_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !fld.unsup |=> out_valid && !out_unsup);

    // R7: an idle cycle is followed by quiet outputs
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !out_unsup);

    // R8: an unsupported request blocks the write and keeps the outputs
    a_r8_unsup_holds: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && fld.unsup |=> out_unsup && !out_valid
                                  && $stable(out_dest) && $stable(out_result));

    // R6: the destination comes from the instruction that was accepted
    a_r6_dest_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !fld.unsup |=> out_dest == $past(insn[7:0]));

    // R4: an immediate B lane is exactly the instruction immediate
    a_r4_imm_lane: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !fld.b_is_reg |-> op_lane[OP_B][15:0] == insn[35:20]);

    // R3: an unsigned byte lane of A has zero upper bits
    a_r3_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !insn[48] && !insn[38] |-> op_lane[OP_A][31:8] == 24'd0);

endmodule

// File: tb/lane_mad_unit_tb.sv
`timescale 1ns/1ps
module lane_mad_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] insn = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] src_c = '0;
    logic        out_valid;
    logic        out_unsup;
    logic [7:0]  out_dest;
    logic [31:0] out_result;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lane_mad_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .insn       (insn),
        .src_a      (src_a),
        .src_b      (src_b),
        .src_c      (src_c),
        .out_valid  (out_valid),
        .out_unsup  (out_unsup),
        .out_dest   (out_dest),
        .out_result (out_result)
    );

    // a3 = insn[38:36], b3 = insn[30:28]
    function automatic logic [63:0] mk(input logic [7:0] dest, input logic [2:0] a3,
                                       input logic [2:0] b3, input logic asg, input logic bsg,
                                       input logic breg, input logic [15:0] imm);
        logic [63:0] w;
        w = 64'(dest);
        if (breg) w[30:28] = b3;
        else      w[35:20] = imm;
        w[38:36] = a3;
        w[48] = asg;
        w[49] = bsg;
        w[50] = breg;
        return w;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [63:0] w, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c);
        @(negedge clk);
        insn = w; src_a = a; src_b = b; src_c = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_result(input string req, input logic [7:0] dest,
                                 input logic [31:0] res);
        chk(req, "out_valid", 32'(out_valid), 32'd1);
        chk(req, "out_unsup", 32'(out_unsup), 32'd0);
        chk(req, "out_dest", 32'(out_dest), 32'(dest));
        chk(req, "out_result", out_result, res);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9", "valid in reset", 32'(out_valid), 32'd0);
        chk("R9", "unsup in reset", 32'(out_unsup), 32'd0);
        chk("R9", "dest in reset", 32'(out_dest), 32'd0);
        chk("R9", "result in reset", out_result, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_byte_lanes();
        // R1 R2: width 0 byte, sel 1 -> 0xFF unsigned; B word
        issue(mk(8'h12, 3'b001, 3'b111, 1'b0, 1'b0, 1'b1, 16'h0), 32'h0000_FF00, 32'd3, 32'd10);
        expect_result("R2", 8'h12, 32'd775);
        // R1 R3: width 1 byte, sel 3 -> 0x80 signed = -128
        issue(mk(8'h21, 3'b011, 3'b111, 1'b1, 1'b0, 1'b1, 16'h0), 32'h8000_0000, 32'd5, 32'd1000);
        expect_result("R3", 8'h21, 32'd360);
        // R3: same byte unsigned = 128
        issue(mk(8'h22, 3'b011, 3'b111, 1'b0, 1'b0, 1'b1, 16'h0), 32'h8000_0000, 32'd5, 32'd0);
        expect_result("R3", 8'h22, 32'd640);
    endtask

    task automatic t_halfword();
        // R2 R3: A halfword high signed = -1, B byte lane 1 unsigned = 127
        issue(mk(8'h31, 3'b101, 3'b001, 1'b1, 1'b0, 1'b1, 16'h0), 32'hFFFF_0000, 32'h0000_7F00, 32'd0);
        expect_result("R2", 8'h31, 32'hFFFF_FF81);
        // R2: A halfword low = 5, B word 0x10000
        issue(mk(8'h32, 3'b100, 3'b110, 1'b0, 1'b0, 1'b1, 16'h0), 32'h1234_0005, 32'h0001_0000, 32'd7);
        expect_result("R2", 8'h32, 32'h0005_0007);
    endtask

    task automatic t_word();
        // R5: product 2^32 truncates to zero; sign flags set but no effect on word lanes
        issue(mk(8'h41, 3'b110, 3'b111, 1'b1, 1'b1, 1'b1, 16'h0), 32'h0001_0000, 32'h0001_0000, 32'h0000_DEAD);
        expect_result("R5", 8'h41, 32'h0000_DEAD);
        // R5: wraparound of the addition
        issue(mk(8'h42, 3'b110, 3'b111, 1'b0, 1'b0, 1'b1, 16'h0), 32'd2, 32'd3, 32'hFFFF_FFFF);
        expect_result("R5", 8'h42, 32'd5);
    endtask

    task automatic t_immediate();
        // R4: imm 0xFFFE signed = -2; src_b ignored; its field bits read as word sel 3
        issue(mk(8'h51, 3'b110, 3'b000, 1'b0, 1'b1, 1'b0, 16'hFFFE), 32'd100, 32'h1234_5678, 32'd50);
        expect_result("R4", 8'h51, 32'hFFFF_FF6A);
        // R4: same imm unsigned = 65534
        issue(mk(8'h52, 3'b110, 3'b000, 1'b0, 1'b0, 1'b0, 16'hFFFE), 32'd2, 32'h1234_5678, 32'd0);
        expect_result("R4", 8'h52, 32'd131068);
        // R4: imm 0x0102 with fields that read as byte width; full halfword is used
        issue(mk(8'h53, 3'b110, 3'b000, 1'b0, 1'b0, 1'b0, 16'h0102), 32'd1, 32'hFFFF_FFFF, 32'd0);
        expect_result("R4", 8'h53, 32'h0000_0102);
    endtask

    task automatic t_unsupported();
        int bits [6] = '{47, 51, 52, 53, 54, 55};
        issue(mk(8'h55, 3'b110, 3'b111, 1'b0, 1'b0, 1'b1, 16'h0), 32'd6, 32'd7, 32'd0);
        expect_result("R8", 8'h55, 32'd42);
        foreach (bits[i]) begin
            logic [63:0] w;
            w = mk(8'hAA, 3'b110, 3'b111, 1'b0, 1'b0, 1'b1, 16'h0);
            w[bits[i]] = 1'b1;
            issue(w, 32'd9, 32'd9, 32'd9);
            chk("R8", $sformatf("valid bit%0d", bits[i]), 32'(out_valid), 32'd0);
            chk("R8", $sformatf("unsup bit%0d", bits[i]), 32'(out_unsup), 32'd1);
            chk("R8", $sformatf("dest kept bit%0d", bits[i]), 32'(out_dest), 32'h55);
            chk("R8", $sformatf("result kept bit%0d", bits[i]), out_result, 32'd42);
        end
    endtask

    task automatic t_idle();
        issue(mk(8'h61, 3'b110, 3'b111, 1'b0, 1'b0, 1'b1, 16'h0), 32'd4, 32'd4, 32'd4);
        expect_result("R7", 8'h61, 32'd20);
        @(negedge clk);
        chk("R7", "valid after idle", 32'(out_valid), 32'd0);
        chk("R7", "unsup after idle", 32'(out_unsup), 32'd0);
        chk("R7", "result held idle", out_result, 32'd20);
    endtask

    initial begin
        t_reset();
        t_byte_lanes();
        t_halfword();
        t_word();
        t_immediate();
        t_unsupported();
        t_idle();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule